// File: doc/BRIEF.md
# Byte-Serial Link Transmitter with Acknowledge Flow Control

This block takes 32-bit words through a valid/ready input and sends each one as four bytes over a point-to-point link. The link has an 8-bit data bus and a clock that the transmitter drives. The receiver returns an acknowledge, which gates when each word may start. While the link is quiet, the clock sits high. When a word is loaded, its first byte goes onto the bus and stays there until the synchronised acknowledge is seen high. The transmitter then drops the clock and sends the bytes, least significant first. Data changes on falling link-clock edges, so the receiver captures on rising ones.

A divider input sets the link rate. At a setting of zero the link runs at the system clock rate, one byte per system cycle. Any other setting N gives a link period of 2N system cycles, split evenly between low and high. The divider is latched when a word starts, so a change only applies from the next word. If acknowledge stays high and the next word is already waiting when the last byte of a word ends, the next word follows with no gap. A status flag and a one-cycle service request are raised only while the block is disabled and holds no word.

Top module: `byte_link_tx`

## Requirements
- R1: During and right after reset, the link clock is high, the data bus is 0x00, `in_ready_o` is low, and both status outputs are low until the first clock edge after reset.
- R2: With a divider setting of 0, the link clock runs at the system clock rate: successive rising link edges within a word are one system clock period apart.
- R3: With a divider setting N > 0, the link clock period is 2N system clock periods, and every byte is one full period.
- R4: A word goes out as four bytes, bits [7:0] first and bits [31:24] last, one byte per rising link-clock edge. With N > 0, the data bus changes during a transfer only when the link clock goes low.
- R5: A loaded word does not start until the synchronised acknowledge is high. Until then the link clock stays high and bits [7:0] of the word stay on the bus.
- R6: Once a word has started, acknowledge going low does not stall its remaining bytes.
- R7: If acknowledge is high and a next word is valid at the end of the last byte, the next word is taken and starts with no extra link-clock period. Acknowledge is only checked at word boundaries.
- R8: Words are accepted only while enabled, and only when no word is held or when the last byte is ending with acknowledge high. While disabled, `in_ready_o` stays low and a presented word is never taken.
- R9: Deasserting the enable in the middle of a word lets that word finish all four bytes.
- R10: `stat_o` is high only while the block is disabled and holds no word. `irq_o` is a one-cycle pulse when `stat_o` rises.
- R11: The divider setting is latched when a word starts, so changing it in the middle of a word does not change that word's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Transmitter enable |
| div_i | input | DIV_W | Link clock divider setting (0 = system rate) |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | WORD_W | Input word |
| in_ready_o | output | 1 | Input word accepted at this clock edge when valid |
| ack_i | input | 1 | Acknowledge from the receiver (asynchronous) |
| lnk_clk_o | output | 1 | Link clock, parks high |
| lnk_dat_o | output | BYTE_W | Link data byte |
| stat_o | output | 1 | Disabled and drained |
| irq_o | output | 1 | One-cycle service request when `stat_o` rises |

## Verification
A receiver model in the bench captures bytes on rising link-clock edges and records when each edge occurs. The main function is driven with random words under several divider settings, including zero. This separates byte-order faults from rate faults, and shows whether the bypass path and the divided path differ. Directed patterns cover the remaining cases. Holding acknowledge low shows whether the first byte is held and the clock parked. Dropping acknowledge after one byte shows whether a started word stalls. Streamed words show whether the boundary adds a gap. Changing the divider or the enable mid-word shows what is latched and what is allowed to finish.

// File: rtl/byte_link_pkg.sv
`timescale 1ns/1ps
package byte_link_pkg;
  typedef enum logic [1:0] {
    LS_PARK = 2'd0,
    LS_LOW  = 2'd1,
    LS_HIGH = 2'd2
  } link_state_e;
endpackage

// File: rtl/bl_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a single asynchronous level.
module bl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) ff_q <= '0;
        else       ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) ff_q <= '0;
        else       ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/bl_phase.sv
`timescale 1ns/1ps
// Half-period counter: loaded at each phase start, flags the last cycle.
module bl_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             last_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (div_i == '0) ? '0 : div_i - DIV_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/bl_shift.sv
`timescale 1ns/1ps
// Word-to-byte serialiser, least significant byte first.
module bl_shift #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              adv_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              last_o
);
  localparam int NB    = WORD_W / BYTE_W;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic [WORD_W-1:0] rest_q;
  logic [BYTE_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rest_q <= '0;
      byte_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      byte_q <= word_i[BYTE_W-1:0];
      rest_q <= word_i >> BYTE_W;
      idx_q  <= '0;
    end else if (adv_i) begin
      byte_q <= rest_q[BYTE_W-1:0];
      rest_q <= rest_q >> BYTE_W;
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign byte_o = byte_q;
  assign last_o = (idx_q == IDX_W'(NB - 1));
endmodule

// File: rtl/bl_clkout.sv
`timescale 1ns/1ps
// Link clock output: registered divided clock, or gated inverted system
// clock when the divider is bypassed. The gate is updated on the falling
// system edge, while the inverted clock is already high.
module bl_clkout (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bypass_i,
  input  logic run_next_i,
  input  logic div_clk_i,
  output logic lnk_clk_o
);
  logic gate_q;

  always_ff @(negedge clk_i) begin
    if (rst_i) gate_q <= 1'b0;
    else       gate_q <= run_next_i;
  end

  assign lnk_clk_o = bypass_i ? (~clk_i | ~gate_q) : div_clk_i;
endmodule

// File: rtl/byte_link_tx.sv
`timescale 1ns/1ps
module byte_link_tx
  import byte_link_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              ack_i,
  output logic              lnk_clk_o,
  output logic [BYTE_W-1:0] lnk_dat_o,
  output logic              stat_o,
  output logic              irq_o
);
  link_state_e      st_q, st_d;
  logic [DIV_W-1:0] div_q;
  logic             have_q, have_d;
  logic             clk_q;
  logic             stat_q, irq_q;
  logic             ack_s;
  logic             bypass;
  logic             ph_last, ph_load;
  logic [DIV_W-1:0] ph_val;
  logic             last_byte;
  logic             end_byte, low_done;
  logic             start, reload, take_idle, byte_adv;
  logic             drained;

  bl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  assign bypass    = (div_q == '0);
  assign end_byte  = (st_q == LS_LOW && bypass) || (st_q == LS_HIGH && ph_last);
  assign low_done  = (st_q == LS_LOW) && !bypass && ph_last;
  assign start     = (st_q == LS_PARK) && have_q && en_i && ack_s;
  assign reload    = end_byte && last_byte && en_i && ack_s && in_valid_i;
  assign take_idle = en_i && (st_q == LS_PARK) && !have_q && in_valid_i;
  assign byte_adv  = end_byte && !last_byte;
  assign in_ready_o = en_i && (((st_q == LS_PARK) && !have_q) ||
                               (end_byte && last_byte && ack_s));

  // phase counter reload: new words use the fresh setting
  assign ph_load = start || low_done || end_byte;
  assign ph_val  = (start || reload) ? div_i : div_q;

  bl_phase #(.DIV_W(DIV_W)) u_phase (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (ph_load),
    .div_i  (ph_val),
    .last_o (ph_last)
  );

  bl_shift #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (take_idle || reload),
    .word_i (in_data_i),
    .adv_i  (byte_adv),
    .byte_o (lnk_dat_o),
    .last_o (last_byte)
  );

  always_comb begin
    st_d   = st_q;
    have_d = have_q;
    if (take_idle) have_d = 1'b1;
    unique case (st_q)
      LS_PARK: begin
        if (start) st_d = LS_LOW;
      end
      LS_LOW: begin
        if (bypass) begin
          if (last_byte && !reload) begin
            st_d   = LS_PARK;
            have_d = 1'b0;
          end
        end else if (ph_last) begin
          st_d = LS_HIGH;
        end
      end
      LS_HIGH: begin
        if (ph_last) begin
          if (!last_byte || reload) begin
            st_d = LS_LOW;
          end else begin
            st_d   = LS_PARK;
            have_d = 1'b0;
          end
        end
      end
      default: st_d = LS_PARK;
    endcase
  end

  assign drained = !en_i && (st_q == LS_PARK) && !have_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= LS_PARK;
      have_q <= 1'b0;
      clk_q  <= 1'b1;
      div_q  <= DIV_W'(1);
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      have_q <= have_d;
      clk_q  <= (st_d != LS_LOW);
      if (start || reload) div_q <= div_i;
      stat_q <= drained;
      irq_q  <= drained && !stat_q;
    end
  end

  bl_clkout u_clkout (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bypass_i   (bypass),
    .run_next_i (st_d == LS_LOW),
    .div_clk_i  (clk_q),
    .lnk_clk_o  (lnk_clk_o)
  );

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/byte_link_chk.sv
`timescale 1ns/1ps
module byte_link_chk
  import byte_link_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              en_i,
  input logic              ack_s_i,
  input link_state_e       st_i,
  input logic              have_i,
  input logic              bypass_i,
  input logic              in_ready_i,
  input logic              lnk_clk_i,
  input logic [BYTE_W-1:0] lnk_dat_i,
  input logic              stat_i,
  input logic              irq_i
);
  AST_PARK_CLK_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_i == LS_PARK && !bypass_i) |-> lnk_clk_i);  // R5

  AST_START_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_i == LS_LOW && $past(st_i == LS_PARK)) |-> $past(ack_s_i));  // R5

  AST_FIRST_BYTE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_i == LS_PARK && have_i && $past(st_i == LS_PARK && have_i)) |-> $stable(lnk_dat_i));  // R5

  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    (!bypass_i && st_i != LS_PARK && !$stable(lnk_dat_i)) |-> !lnk_clk_i);  // R4

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_ready_i && st_i == LS_PARK) |-> !have_i);  // R8

  AST_STAT_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    stat_i |-> !$past(en_i));  // R10

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i |=> !irq_i);  // R10
endmodule

bind byte_link_tx byte_link_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .en_i       (en_i),
  .ack_s_i    (ack_s),
  .st_i       (st_q),
  .have_i     (have_q),
  .bypass_i   (bypass),
  .in_ready_i (in_ready_o),
  .lnk_clk_i  (lnk_clk_o),
  .lnk_dat_i  (lnk_dat_o),
  .stat_i     (stat_o),
  .irq_i      (irq_o)
);

// File: tb/test_byte_link_tx.sv
`timescale 1ns/1ps
module test_byte_link_tx;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [7:0]  div = 8'd1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        ack = 1'b0;
  logic        lnk_clk;
  logic [7:0]  lnk_dat;
  logic        stat;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int irq_n  = 0;
  int rx_n   = 0;
  logic [7:0] rx_b [0:511];
  longint     rx_t [0:511];

  byte_link_tx i_byte_link_tx (
    .clk_i      (clk),
    .rst_i      (rst),
    .en_i       (en),
    .div_i      (div),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .in_ready_o (in_ready),
    .ack_i      (ack),
    .lnk_clk_o  (lnk_clk),
    .lnk_dat_o  (lnk_dat),
    .stat_o     (stat),
    .irq_o      (irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  // receiver model: capture on rising link edges
  always @(posedge lnk_clk) begin
    if (!rst && rx_n < 512) begin
      rx_b[rx_n] = lnk_dat;
      rx_t[rx_n] = $time;
      rx_n++;
    end
  end

  always begin
    @(posedge clk);
    #1;
    if (!rst && irq) irq_n++;
  end

  function automatic longint exp_gap(input int d);
    return (d == 0) ? longint'(CLK_NS) : longint'(2 * d * CLK_NS);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_rx(input int target, input string req);
    int n = 0;
    while (rx_n < target && n < 3000) begin
      step(1);
      n++;
    end
    chk(rx_n >= target, req, "bytes received", rx_n, target);
  endtask

  task automatic push(input logic [31:0] w);
    int  n = 0;
    bit  r;
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      r = in_ready;
      step(1);
      n++;
      if (r || n > 3000) break;
    end
    chk(r, "R8", "word accepted", 0, 1);
    in_valid = 1'b0;
  endtask

  task automatic check_word(input int base, input logic [31:0] w, input string req);
    for (int k = 0; k < 4; k++)
      chk(rx_b[base+k] == w[8*k +: 8], req, $sformatf("byte %0d", k),
          rx_b[base+k], w[8*k +: 8]);
  endtask

  task automatic check_gaps(input int first, input int last, input int d, input string req);
    for (int i = first + 1; i <= last; i++)
      chk(rx_t[i] - rx_t[i-1] == exp_gap(d), req, $sformatf("edge gap %0d", i),
          rx_t[i] - rx_t[i-1], exp_gap(d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [31:0] wa [0:2];
    int base;
    int d;
    int irq_before;
    void'($urandom(32'd4242));

    step(5);
    rst = 1'b0;
    #1;
    chk(lnk_clk == 1'b1, "R1", "link clock after reset", lnk_clk, 1);
    chk(lnk_dat == 8'h00, "R1", "link data after reset", lnk_dat, 0);
    chk(in_ready == 1'b0, "R1", "ready after reset", in_ready, 0);
    chk(stat == 1'b0 && irq == 1'b0, "R1", "status after reset", {stat, irq}, 0);
    step(3);
    chk(stat == 1'b1, "R10", "status when disabled and empty", stat, 1);
    chk(irq_n == 1, "R10", "irq pulses", irq_n, 1);

    // R5: word waits for acknowledge
    en = 1'b1;
    div = 8'd2;
    step(2);
    chk(stat == 1'b0, "R10", "status cleared when enabled", stat, 0);
    w = 32'hA1B2C3D4;
    push(w);
    step(20);
    chk(rx_n == 0, "R5", "no edge without ack", rx_n, 0);
    chk(lnk_dat == 8'hD4, "R5", "first byte held", lnk_dat, 8'hD4);
    chk(lnk_clk == 1'b1, "R5", "clock parked high", lnk_clk, 1);
    chk(in_ready == 1'b0, "R8", "no ready while word held", in_ready, 0);
    ack = 1'b1;
    wait_rx(4, "R5");
    check_word(0, w, "R4");
    check_gaps(0, 3, 2, "R3");

    // R6: ack drops after first byte
    step(4);
    base = rx_n;
    w = 32'h11223344;
    push(w);
    wait_rx(base + 1, "R6");
    ack = 1'b0;
    wait_rx(base + 4, "R6");
    check_word(base, w, "R6");
    check_gaps(base, base + 3, 2, "R6");

    // random words over several divider settings
    ack = 1'b1;
    for (int i = 0; i < 12; i++) begin
      d = $urandom_range(0, 3);
      div = 8'(d);
      w = $urandom;
      step(4);
      base = rx_n;
      push(w);
      wait_rx(base + 4, (d == 0) ? "R2" : "R3");
      check_word(base, w, "R4");
      check_gaps(base, base + 3, d, (d == 0) ? "R2" : "R3");
      step(2 * d + 4);
    end

    // R11: divider change mid-word
    div = 8'd1;
    step(2);
    base = rx_n;
    w = 32'hCAFE0B0E;
    push(w);
    wait_rx(base + 1, "R11");
    div = 8'd4;
    wait_rx(base + 4, "R11");
    check_word(base, w, "R11");
    check_gaps(base, base + 3, 1, "R11");
    step(10);

    // R7: streamed words, divided and bypassed
    for (int m = 0; m < 2; m++) begin
      d = (m == 0) ? 1 : 0;
      div = 8'(d);
      for (int k = 0; k < 3; k++) wa[k] = $urandom;
      step(4);
      base = rx_n;
      fork
        begin
          push(wa[0]);
          push(wa[1]);
          push(wa[2]);
        end
      join_none
      wait_rx(base + 12, "R7");
      for (int k = 0; k < 3; k++) check_word(base + 4*k, wa[k], "R7");
      check_gaps(base, base + 11, d, "R7");
      step(10);
    end

    // R9: disable mid-word
    div = 8'd3;
    step(2);
    base = rx_n;
    irq_before = irq_n;
    w = 32'h5A6B7C8D;
    push(w);
    wait_rx(base + 1, "R9");
    en = 1'b0;
    wait_rx(base + 4, "R9");
    check_word(base, w, "R9");
    step(10);
    chk(stat == 1'b1, "R10", "status after drain", stat, 1);
    chk(irq_n == irq_before + 1, "R10", "single irq pulse", irq_n, irq_before + 1);

    // R8: word offered while disabled is not taken
    base = rx_n;
    in_valid = 1'b1;
    in_data  = 32'hDEADBEEF;
    step(1);
    chk(in_ready == 1'b0, "R8", "ready while disabled", in_ready, 0);
    step(20);
    chk(in_ready == 1'b0, "R8", "ready while disabled later", in_ready, 0);
    in_valid = 1'b0;
    en = 1'b1;
    step(40);
    chk(rx_n == base, "R8", "nothing sent after re-enable", rx_n, base);
    chk(stat == 1'b0, "R10", "status low when enabled", stat, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule